// File: doc/BRIEF.md
# Single-Precision Round and Pack Stage

This stage takes an intermediate floating-point value held as a sign, a signed unbiased exponent and a 27-bit extended mantissa, and produces a packed 32-bit single-precision word. The mantissa carries a 24-bit significand with its leading one at bit 26, and three low bits below the significand LSB that hold guard, round and sticky information. An arithmetic datapath such as an adder, a multiplier or a converter places one of these stage at its output. The datapath supplies the unrounded value, and this stage applies the rounding mode. It also handles values too small or too large for the format, and reports the inexact, underflow and overflow conditions.

Each operation takes one cycle. When `in_valid` is high, the operands are captured, and the packed result and its flags show up on the registered outputs on the next cycle, along with `out_valid`. The rounding mode, the flush enable and the underflow trap enable are sampled with the operands. Callers must not present a mantissa with bit 26 clear or a NaN operand.

Top module: `rp_round_pack`

## Requirements
- R1: `out_valid` equals `in_valid` from the previous clock edge, and results appear one cycle after capture. A synchronous active-high reset clears `out_valid`, `out_word` and all three flags to zero.
- R2: Rounding takes place only when mantissa bits [2:0] are non-zero, and `flag_inexact` is then raised. Mode 00 (nearest) rounds ties to an even significand: a tail of 100 rounds up only when bit 3 is one, a tail above 100 rounds up and a tail below 100 truncates.
- R3: Mode 01 truncates. Mode 10 raises the magnitude by one LSB for a positive sign only. Mode 11 raises the magnitude by one LSB for a negative sign only.
- R4: When rounding carries beyond bit 26, the significand is shifted right by one and the exponent is incremented.
- R5: If the exponent after rounding exceeds 127, `flag_overflow` and `flag_inexact` are raised. The result is then: infinity (biased exponent 255, fraction 0) in mode 00; the largest finite value (biased exponent 254, fraction all ones) in mode 01; +infinity or -max in mode 10, depending on a positive or negative sign; +max or -infinity in mode 11, depending on a positive or negative sign.
- R6: With `flush_en` high and an input exponent below -126, `flag_underflow` and `flag_inexact` are raised. The result is: a zero of the input sign in modes 00 and 01; +min-denormal (fraction 1) or -0 in mode 10; +0 or -min-denormal in mode 11.
- R7: With flush disabled and an exponent below -126, the mantissa is shifted right by (-126 - exponent). Every bit shifted out is ORed into bit 0, and a shift of 27 or more leaves only that sticky one. The exponent becomes -126 and the value is then rounded.
- R8: For an exponent of exactly -127, if rounding the unshifted mantissa would carry beyond bit 26, the result is the smallest normal (biased exponent 1, fraction 0). `flag_inexact` is raised and `flag_underflow` is not.
- R9: `flag_underflow` is raised when rounding is needed and bit 26 is clear just before rounding. When the final significand has no leading one, the result has biased exponent 0, and `flag_underflow` is raised in addition only if `uf_trap_en` is high.
- R10: A normal result has biased exponent (exponent + 127) and its fraction is significand bits [22:0]. An input with bits [2:0] clear and an exponent in [-126, 127] gives no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | IN_EXP_W | Signed unbiased exponent |
| in_mant | input | 27 | Extended mantissa, leading one at bit 26, bits [2:0] guard/round/sticky |
| rnd_mode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| flush_en | input | 1 | Replace tiny values by the mode-dependent flush result |
| uf_trap_en | input | 1 | Also flag underflow for exact subnormal results |
| out_valid | output | 1 | Result present |
| out_word | output | 32 | Packed single-precision result |
| flag_inexact | output | 1 | Result differs from the exact value |
| flag_underflow | output | 1 | Tiny result condition |
| flag_overflow | output | 1 | Exponent out of range above |

## Verification
The hardest situation to reach is the exponent -127 boundary. There the carry-out test is made on the mantissa before the sticky shift, so only mantissas that are all ones or nearly all ones take the smallest-normal path, and a neighbouring value takes the subnormal path instead. The stimulus places all-ones and lightly set mantissas exactly at -127. It also places them at -126 to -160, in every rounding mode, with each sign, and with flush and trap both on and off. A seeded pseudo-random sweep of exponents across both range edges then covers mixes the directed cases miss.

// File: rtl/rp_pkg.sv
package rp_pkg;

    localparam int SIG_W   = 24;
    localparam int XTRA_W  = 3;
    localparam int MANT_W  = SIG_W + XTRA_W;
    localparam int FRAC_W  = SIG_W - 1;
    localparam int BEXP_W  = 8;
    localparam int BIAS    = 127;
    localparam int EMIN    = -126;
    localparam int EMAX    = 127;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_UP   = 2'b10,
        RM_DOWN = 2'b11
    } rmode_e;

    typedef struct packed {
        logic                sign;
        logic [BEXP_W-1:0]   bexp;
        logic [FRAC_W-1:0]   frac;
    } sp_word_t;

    typedef struct packed {
        logic nx;
        logic uf;
        logic ov;
    } flags_t;

    function automatic sp_word_t sp_zero(input logic s);
        sp_word_t w;
        w.sign = s;
        w.bexp = '0;
        w.frac = '0;
        return w;
    endfunction

    function automatic sp_word_t sp_min_sub(input logic s);
        sp_word_t w;
        w.sign = s;
        w.bexp = '0;
        w.frac = FRAC_W'(1);
        return w;
    endfunction

    function automatic sp_word_t sp_max(input logic s);
        sp_word_t w;
        w.sign = s;
        w.bexp = {{(BEXP_W-1){1'b1}}, 1'b0};
        w.frac = '1;
        return w;
    endfunction

    function automatic sp_word_t sp_inf(input logic s);
        sp_word_t w;
        w.sign = s;
        w.bexp = '1;
        w.frac = '0;
        return w;
    endfunction

endpackage

// File: rtl/rp_round_inc.sv
module rp_round_inc
    import rp_pkg::*;
#(
    parameter int W = MANT_W
) (
    input  logic         sign,
    input  rmode_e       mode,
    input  logic [W-1:0] mant,
    output logic         need,
    output logic [W:0]   rounded
);
    logic [3:0] inc;

    assign need = |mant[XTRA_W-1:0];

    always_comb begin
        inc = 4'd0;
        unique case (mode)
            RM_NEAR: inc = 4'd3 + {3'd0, mant[XTRA_W]};
            RM_ZERO: inc = 4'd0;
            RM_UP:   inc = sign ? 4'd0 : 4'd8;
            RM_DOWN: inc = sign ? 4'd8 : 4'd0;
            default: inc = 4'd0;
        endcase
    end

    assign rounded = need ? ({1'b0, mant} + (W+1)'(inc)) : {1'b0, mant};

endmodule

// File: rtl/rp_sticky_shr.sv
module rp_sticky_shr #(
    parameter int W  = 27,
    parameter int AW = 12
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  dout
);
    localparam int NST = $clog2(W);

    logic [W-1:0] stg [NST+1];

    assign stg[0] = din;

    for (genvar k = 0; k < NST; k++) begin : g_stage
        localparam int S = 1 << k;
        logic         lost;
        logic [W-1:0] shd;
        assign lost       = |stg[k][S-1:0];
        assign shd        = stg[k] >> S;
        assign stg[k+1]   = amt[k] ? (shd | W'(lost)) : stg[k];
    end

    assign dout = (amt >= AW'(W)) ? W'(|din) : stg[NST];

endmodule

// File: rtl/rp_exc_result.sv
module rp_exc_result
    import rp_pkg::*;
(
    input  logic     sign,
    input  rmode_e   mode,
    input  logic     is_ovf,
    output sp_word_t word
);
    always_comb begin
        if (is_ovf) begin
            unique case (mode)
                RM_NEAR: word = sp_inf(sign);
                RM_ZERO: word = sp_max(sign);
                RM_UP:   word = sign ? sp_max(sign) : sp_inf(sign);
                RM_DOWN: word = sign ? sp_inf(sign) : sp_max(sign);
                default: word = sp_inf(sign);
            endcase
        end else begin
            unique case (mode)
                RM_NEAR: word = sp_zero(sign);
                RM_ZERO: word = sp_zero(sign);
                RM_UP:   word = sign ? sp_zero(sign) : sp_min_sub(sign);
                RM_DOWN: word = sign ? sp_min_sub(sign) : sp_zero(sign);
                default: word = sp_zero(sign);
            endcase
        end
    end

endmodule

// File: rtl/rp_round_pack.sv
module rp_round_pack
    import rp_pkg::*;
#(
    parameter int IN_EXP_W = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic                       in_sign,
    input  logic signed [IN_EXP_W-1:0] in_exp,
    input  logic [MANT_W-1:0]          in_mant,
    input  logic [1:0]                 rnd_mode,
    input  logic                       flush_en,
    input  logic                       uf_trap_en,
    output logic                       out_valid,
    output logic [31:0]                out_word,
    output logic                       flag_inexact,
    output logic                       flag_underflow,
    output logic                       flag_overflow
);
    localparam int EW = IN_EXP_W + 2;
    localparam logic signed [EW-1:0] EMIN_X = EW'(EMIN);
    localparam logic signed [EW-1:0] EMAX_X = EW'(EMAX);
    localparam logic signed [EW-1:0] BIAS_X = EW'(BIAS);

    rmode_e mode;
    assign mode = rmode_e'(rnd_mode);

    logic signed [EW-1:0] e_x;
    assign e_x = EW'(in_exp);

    logic is_tiny, at_edge, flushing, not_tiny;
    assign is_tiny  = e_x < EMIN_X;
    assign at_edge  = e_x == (EMIN_X - EW'(1));
    assign flushing = is_tiny && flush_en;

    // boundary test: round the mantissa at its unshifted position
    logic              pre_need;
    logic [MANT_W:0]   pre_rnd;
    rp_round_inc #(.W(MANT_W)) u_pre_rnd (
        .sign    (in_sign),
        .mode    (mode),
        .mant    (in_mant),
        .need    (pre_need),
        .rounded (pre_rnd)
    );
    assign not_tiny = at_edge && pre_rnd[MANT_W];

    logic [EW-1:0]     shamt;
    logic [MANT_W-1:0] sh_mant;
    assign shamt = EMIN_X - e_x;
    rp_sticky_shr #(.W(MANT_W), .AW(EW)) u_shr (
        .din  (in_mant),
        .amt  (shamt),
        .dout (sh_mant)
    );

    logic [MANT_W-1:0]    m1;
    logic signed [EW-1:0] exp1;
    always_comb begin
        if (!is_tiny) begin
            m1   = in_mant;
            exp1 = e_x;
        end else if (not_tiny) begin
            m1   = {pre_rnd[MANT_W:XTRA_W+1], {XTRA_W{1'b0}}};
            exp1 = EMIN_X;
        end else begin
            m1   = sh_mant;
            exp1 = EMIN_X;
        end
    end

    logic            need1;
    logic [MANT_W:0] r1;
    rp_round_inc #(.W(MANT_W)) u_main_rnd (
        .sign    (in_sign),
        .mode    (mode),
        .mant    (m1),
        .need    (need1),
        .rounded (r1)
    );

    logic                 uf_pre;
    logic [MANT_W-1:0]    m2;
    logic signed [EW-1:0] exp2;
    assign uf_pre = need1 && !m1[MANT_W-1];

    always_comb begin
        if (need1 && r1[MANT_W]) begin
            m2   = r1[MANT_W:1];
            exp2 = exp1 + EW'(1);
        end else begin
            m2   = r1[MANT_W-1:0];
            exp2 = exp1;
        end
    end

    logic [SIG_W-1:0] sig;
    logic             is_ovf;
    logic [EW-1:0]    bexp_full;
    assign sig       = m2[MANT_W-1:XTRA_W];
    assign is_ovf    = exp2 > EMAX_X;
    assign bexp_full = exp2 + BIAS_X;

    sp_word_t exc_word;
    rp_exc_result u_exc (
        .sign   (in_sign),
        .mode   (mode),
        .is_ovf (!flushing),
        .word   (exc_word)
    );

    sp_word_t res_word;
    flags_t   res_flags;
    always_comb begin
        res_word.sign = in_sign;
        res_word.frac = sig[FRAC_W-1:0];
        res_word.bexp = bexp_full[BEXP_W-1:0];
        res_flags.nx  = need1 || not_tiny;
        res_flags.uf  = uf_pre;
        res_flags.ov  = 1'b0;
        if (flushing) begin
            res_word     = exc_word;
            res_flags.nx = 1'b1;
            res_flags.uf = 1'b1;
        end else if (is_ovf) begin
            res_word     = exc_word;
            res_flags.nx = 1'b1;
            res_flags.ov = 1'b1;
        end else if (!sig[SIG_W-1]) begin
            res_word.bexp = '0;
            res_flags.uf  = uf_pre || uf_trap_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid      <= 1'b0;
            out_word       <= '0;
            flag_inexact   <= 1'b0;
            flag_underflow <= 1'b0;
            flag_overflow  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word       <= res_word;
                flag_inexact   <= res_flags.nx;
                flag_underflow <= res_flags.uf;
                flag_overflow  <= res_flags.ov;
            end
        end
    end

endmodule

// File: rtl/rp_round_pack_chk.sv
module rp_round_pack_chk #(
    parameter int IN_EXP_W = 10
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       in_valid,
    input logic signed [IN_EXP_W-1:0] in_exp,
    input logic [26:0]                in_mant,
    input logic                       flush_en,
    input logic                       out_valid,
    input logic [31:0]                out_word,
    input logic                       flag_inexact,
    input logic                       flag_underflow,
    input logic                       flag_overflow
);
    // R1: one-cycle valid latency
    p_valid_lat_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R5: overflow always inexact, exponent field saturated
    p_ovf_nx_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && flag_overflow) |-> flag_inexact);
    p_ovf_code_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && flag_overflow) |-> (out_word[30:23] >= 8'hFE));
    p_ovf_uf_excl_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(flag_overflow && flag_underflow));

    // R6: flush gives zero or min denormal with underflow and inexact
    p_flush_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && flush_en && ($signed(in_exp) < -126))
        |=> (flag_underflow && flag_inexact && !flag_overflow
             && (out_word[30:0] <= 31'd1)));

    // R10: exact in-range input raises nothing
    p_exact_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_mant[2:0] == 3'b000) && ($signed(in_exp) >= -126)
         && ($signed(in_exp) <= 127))
        |=> (!flag_inexact && !flag_overflow && !flag_underflow));

endmodule

bind rp_round_pack rp_round_pack_chk #(.IN_EXP_W(IN_EXP_W)) u_rp_chk (
    .clk            (clk),
    .rst            (rst),
    .in_valid       (in_valid),
    .in_exp         (in_exp),
    .in_mant        (in_mant),
    .flush_en       (flush_en),
    .out_valid      (out_valid),
    .out_word       (out_word),
    .flag_inexact   (flag_inexact),
    .flag_underflow (flag_underflow),
    .flag_overflow  (flag_overflow)
);

// File: tb/test_rp_round_pack.sv
`timescale 1ns/1ps
module test_rp_round_pack;

    localparam int EW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_sign = 1'b0;
    logic [EW-1:0] in_exp = '0;
    logic [26:0]   in_mant = 27'h4000000;
    logic [1:0]    rnd_mode = 2'b00;
    logic          flush_en = 1'b0;
    logic          uf_trap_en = 1'b0;
    logic          out_valid;
    logic [31:0]   out_word;
    logic          flag_inexact, flag_underflow, flag_overflow;

    always #2 clk = ~clk;

    rp_round_pack #(.IN_EXP_W(EW)) i_rp_round_pack (
        .clk            (clk),
        .rst            (rst),
        .in_valid       (in_valid),
        .in_sign        (in_sign),
        .in_exp         (in_exp),
        .in_mant        (in_mant),
        .rnd_mode       (rnd_mode),
        .flush_en       (flush_en),
        .uf_trap_en     (uf_trap_en),
        .out_valid      (out_valid),
        .out_word       (out_word),
        .flag_inexact   (flag_inexact),
        .flag_underflow (flag_underflow),
        .flag_overflow  (flag_overflow)
    );

    typedef struct {
        bit          vld;
        logic [34:0] res;
        string       tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam longint HID = 64'd1 << 26;

    function automatic longint rnd(bit sn, longint m, int rm);
        if ((m & 7) == 0) return m;
        case (rm)
            0: return m + 3 + ((m >> 3) & 1);
            2: return sn ? m : m + 8;
            3: return sn ? m + 8 : m;
            default: return m;
        endcase
    endfunction

    function automatic longint srs(longint m, int es);
        longint lost;
        if (es >= 27) return (m != 0) ? 64'd1 : 64'd0;
        lost = m & ((64'd1 << es) - 1);
        return (m >> es) | ((lost != 0) ? 64'd1 : 64'd0);
    endfunction

    // result layout: {word[31:0], nx, uf, ov}
    function automatic logic [34:0] model(bit sn, int e, longint m, int rm, bit fz, bit ut);
        bit nx = 0, uf = 0, ov = 0;
        logic [31:0] w;
        longint r;
        if (e < -126) begin
            if (fz) begin
                if (rm == 2 && !sn)      w = 32'h0000_0001;
                else if (rm == 3 && sn)  w = 32'h8000_0001;
                else                     w = {sn, 31'd0};
                return {w, 3'b110};
            end
            r = rnd(sn, m, rm);
            if (e == -127 && r >= (64'd1 << 27)) begin
                nx = 1;
                m  = (r >> 1) & ~64'd7;
            end else begin
                m = srs(m, -126 - e);
            end
            e = -126;
        end
        if ((m & 7) != 0) begin
            nx = 1;
            if ((m & HID) == 0) uf = 1;
            m = rnd(sn, m, rm);
            if ((m >> 27) != 0) begin
                m = m >> 1;
                e = e + 1;
            end
        end
        m = m >> 3;
        if (e > 127) begin
            ov = 1; nx = 1;
            if (rm == 1 || (rm == 2 && sn) || (rm == 3 && !sn)) w = {sn, 8'hFE, 23'h7FFFFF};
            else                                                   w = {sn, 8'hFF, 23'h0};
            return {w, nx, uf, ov};
        end
        if (((m >> 23) & 1) == 0) begin
            if (ut) uf = 1;
            w = {sn, 8'h00, m[22:0]};
        end else begin
            w = {sn, 8'(e + 127), m[22:0]};
        end
        return {w, nx, uf, ov};
    endfunction

    task automatic check_pending();
        exp_t x;
        if (q.size() == 0) return;
        x = q.pop_front();
        checks++;
        if (out_valid !== x.vld) begin
            errors++;
            $display("FAIL %s out_valid actual %0b expected %0b", x.tag, out_valid, x.vld);
        end else if (x.vld && {out_word, flag_inexact, flag_underflow, flag_overflow} !== x.res) begin
            errors++;
            $display("FAIL %s result actual %h nx%0b uf%0b ov%0b expected %h nx%0b uf%0b ov%0b",
                     x.tag, out_word, flag_inexact, flag_underflow, flag_overflow,
                     x.res[34:3], x.res[2], x.res[1], x.res[0]);
        end
    endtask

    task automatic apply(bit v, bit sn, int e, logic [26:0] m, int rm, bit fz, bit ut, string tag);
        exp_t x;
        @(negedge clk);
        check_pending();
        in_valid   = v;
        in_sign    = sn;
        in_exp     = EW'(e);
        in_mant    = m;
        rnd_mode   = 2'(rm);
        flush_en   = fz;
        uf_trap_en = ut;
        x.vld = v;
        x.res = model(sn, e, longint'(m), rm, fz, ut);
        x.tag = tag;
        q.push_back(x);
    endtask

    task automatic finish_run();
        if (done) return;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired before the stimulus completed");
        finish_run();
    end

    initial begin
        logic [31:0] lf;
        logic [26:0] M;
        M  = 27'h4000000;
        lf = 32'hACE1_1234;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;  // R1 reset state
        if (out_valid !== 1'b0 || out_word !== 32'd0 || flag_inexact !== 1'b0 ||
            flag_underflow !== 1'b0 || flag_overflow !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset state actual v%0b %h expected v0 00000000", out_valid, out_word);
        end
        rst = 1'b0;

        for (int rm = 0; rm < 4; rm++) begin
            for (int s = 0; s < 2; s++) begin
                bit sn;
                sn = bit'(s);
                apply(1, sn, 0,    M | 27'd4,        rm, 0, 0, "R2");
                apply(1, sn, 0,    M | 27'd12,       rm, 0, 0, "R2");
                apply(1, sn, 5,    M | 27'd5,        rm, 0, 0, "R3");
                apply(1, sn, -3,   M | 27'd3,        rm, 0, 0, "R3");
                apply(0, sn, 0,    M,                rm, 0, 0, "R1");
                apply(1, sn, 10,   27'h7FFFFFF,      rm, 0, 0, "R4");
                apply(1, sn, 127,  27'h7FFFFFF,      rm, 0, 0, "R5");
                apply(1, sn, 128,  M,                rm, 0, 0, "R5");
                apply(1, sn, 300,  M | 27'd1,        rm, 0, 0, "R5");
                apply(1, sn, -140, M,                rm, 1, 0, "R6");
                apply(1, sn, -127, 27'h7FFFFFF,      rm, 1, 0, "R6");
                apply(1, sn, -130, M | 27'd9,        rm, 0, 0, "R7");
                apply(1, sn, -149, M,                rm, 0, 0, "R7");
                apply(1, sn, -160, M | 27'd3,        rm, 0, 1, "R7");
                apply(1, sn, -127, 27'h7FFFFFF,      rm, 0, 0, "R8");
                apply(1, sn, -127, 27'h7FFFFFC,      rm, 0, 0, "R8");
                apply(1, sn, -127, M | 27'd1,        rm, 0, 0, "R8");
                apply(1, sn, -127, M,                rm, 0, 1, "R9");
                apply(1, sn, -127, M,                rm, 0, 0, "R9");
                apply(1, sn, -128, M | 27'd2,        rm, 0, 0, "R9");
                apply(1, sn, -126, M,                rm, 0, 1, "R10");
                apply(1, sn, 127,  M | 27'd8,        rm, 0, 0, "R10");
            end
        end

        for (int i = 0; i < 400; i++) begin
            int e;
            logic [26:0] m;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            e  = int'(lf[9:0]) % 341 - 170;
            m  = M | {1'b0, lf[31:6]};
            if (lf[3]) m = m | 27'h3FFFFF8;
            apply(1, lf[2], e, m, int'(lf[5:4]), lf[0] & lf[1], lf[1], "R3");
        end

        @(negedge clk);
        check_pending();
        finish_run();
    end

endmodule